// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter with a small register interface. Its control state (the event flag, the match value, the enable bits and a count restart) is shielded by a two-key unlock handshake. Software first writes one fixed key to a key register and then a second fixed key to another key register. That opens the gate for exactly one write to a guarded register. Any further guarded write needs a fresh pair of keys.

When counting is enabled, the counter climbs by one every clock cycle. When it reaches the programmed match value, a sticky event flag is set and the count wraps to zero. The event drives a level interrupt while counting stays enabled. If the reset enable is also set, the event starts a fixed-length system reset request pulse. The live count can be read at any time without unlocking.

Top module: `kwdt_top`

## Requirements
- R1: After reset the count reads 0, the event flag reads 0, the enable field reads 0, the match value reads all ones (0xFFFF at default width), and irq and rst_req are low.
- R2: Writing 0xBABA to address 0, then writing 0xEB10 to address 1, opens the gate. The next write to a guarded address (2 status, 3 match, 4 enable, 5 restart) then takes effect.
- R3: A guarded write uses up the opened gate. A second guarded write with no new key pair is ignored.
- R4: These actions close the gate: a wrong value at address 0 or at address 1, a write to address 1 that does not directly follow a correct first key, or a guarded write while the gate is only half open. A guarded write made while the gate is closed changes nothing.
- R5: While enable bit 0 (address 4) is 1, the count rises by exactly one per clock. While that bit is 0, the count holds.
- R6: When the count equals the match value and enable bit 0 is 1, the next clock edge sets the event flag (address 2, bit 0) and returns the count to 0.
- R7: irq is high exactly when the event flag is set and enable bit 0 is 1.
- R8: A match that occurs while enable bit 1 is 1 raises rst_req for exactly 16 clock cycles. A match with bit 1 at 0 leaves rst_req low.
- R9: An unlocked write of 0 to address 2 clears the event flag. An unlocked write of a nonzero value leaves the flag as it is. A match in the same cycle as the clear write wins, so the flag stays set.
- R10: An unlocked write of any value to address 5 sets the count to 0. The same write without the keys leaves the count unchanged.
- R11: The count can be read at address 6 at any time, with no unlocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Watchdog event interrupt (level) |
| rst_req | output | 1 | System reset request pulse |

## Verification
A match and an unlocked clear of the event flag can land on the same clock edge, and the match must win. The bench provokes this with a short match value. It lets a first event set the flag and sends the key pair in advance. It then polls the count at every falling edge and drives the clear write at the falling edge where the count equals the match value, so the clear lands on the edge that carries the match. It judges the result by reading the flag back as still set. It then repeats the clear away from any match and expects the flag to read clear.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_e;

  localparam logic [ADDR_W-1:0] A_KEY1    = 3'd0;
  localparam logic [ADDR_W-1:0] A_KEY2    = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESTART = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd6;

  localparam logic [15:0] KEY_FIRST  = 16'hBABA;
  localparam logic [15:0] KEY_SECOND = 16'hEB10;

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == A_STATUS) || (a == A_MATCH) || (a == A_ENABLE) || (a == A_RESTART);
  endfunction

  // Next state of the unlock gate for one write.
  function automatic lock_e lock_next(input lock_e cur, input logic wr_k1, input logic wr_k2,
                                      input logic key_ok, input logic wr_guard);
    lock_e nxt;
    nxt = cur;
    if (wr_k1)         nxt = key_ok ? LK_HALF : LK_CLOSED;
    else if (wr_k2)    nxt = (key_ok && cur == LK_HALF) ? LK_OPEN : LK_CLOSED;
    else if (wr_guard) nxt = LK_CLOSED;
    return nxt;
  endfunction

endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              guard_we,
  output logic              unlocked
);

  lock_e state_q;
  logic  wr_k1, wr_k2, wr_guard, key_ok;

  assign wr_k1    = wr_en && (wr_addr == A_KEY1);
  assign wr_k2    = wr_en && (wr_addr == A_KEY2);
  assign wr_guard = wr_en && is_guarded(wr_addr);
  assign key_ok   = wr_k1 ? (wr_data == DATA_W'(KEY_FIRST)) : (wr_data == DATA_W'(KEY_SECOND));
  assign unlocked = (state_q == LK_OPEN);
  assign guard_we = wr_guard && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= lock_next(state_q, wr_k1, wr_k2, key_ok, wr_guard);
  end

  AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |=> !unlocked); // R3
  AST_KEY2_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_k2 && state_q != LK_HALF) |=> !unlocked); // R4
  AST_KEY1_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_k1 && wr_data != DATA_W'(KEY_FIRST)) |=> (state_q == LK_CLOSED)); // R4

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit,
  output logic              event_q,
  output logic [CNT_W-1:0]  match_q,
  output logic [1:0]        en_q,
  output logic              restart
);

  logic clear_req;

  assign clear_req = guard_we && (wr_addr == A_STATUS) && (wr_data == '0);
  assign restart   = guard_we && (wr_addr == A_RESTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= 1'b0;
      match_q <= '1;
      en_q    <= 2'b00;
    end else begin
      if (hit)            event_q <= 1'b1;
      else if (clear_req) event_q <= 1'b0;
      if (guard_we && wr_addr == A_MATCH)  match_q <= wr_data[CNT_W-1:0];
      if (guard_we && wr_addr == A_ENABLE) en_q    <= wr_data[1:0];
    end
  end

  AST_HIT_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> event_q); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !hit) |=> !event_q); // R9
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q && !guard_we) |=> event_q); // R9

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] match,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit,
  output logic             rst_req
);

  localparam int PW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(RST_CYC);

  logic [PW-1:0] pulse_q;

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c, input logic go,
                                                  input logic zero);
    if (zero)    return '0;
    else if (go) return c + 1'b1;
    else         return c;
  endfunction

  assign hit     = run && (cnt_q == match);
  assign rst_req = (pulse_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else begin
      cnt_q <= count_next(cnt_q, run, hit || restart);
      if (hit && rst_en)     pulse_q <= PULSE_LOAD;
      else if (pulse_q != 0) pulse_q <= pulse_q - 1'b1;
    end
  end

  // Checker-side run length of the reset request.
  logic [15:0] high_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                high_len <= '0;
    else if (!rst_req)         high_len <= '0;
    else if (high_len != '1)   high_len <= high_len + 1'b1;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !hit) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (high_len >= 16'(RST_CYC))); // R8
  AST_NO_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !(hit && rst_en)) |=> !rst_req); // R8

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);

  logic             guard_we, unlocked, hit, event_q, restart;
  logic [CNT_W-1:0] match_q, cnt_q;
  logic [1:0]       en_q;

  kwdt_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .guard_we(guard_we), .unlocked(unlocked)
  );

  kwdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .guard_we(guard_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit(hit), .event_q(event_q), .match_q(match_q), .en_q(en_q), .restart(restart)
  );

  kwdt_counter #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(en_q[0]), .rst_en(en_q[1]), .match(match_q),
    .restart(restart), .cnt_q(cnt_q), .hit(hit), .rst_req(rst_req)
  );

  assign irq = event_q && en_q[0];

  always_comb begin
    case (rd_addr)
      A_STATUS: rd_data = DATA_W'(event_q);
      A_MATCH:  rd_data = DATA_W'(match_q);
      A_ENABLE: rd_data = DATA_W'(en_q);
      A_COUNT:  rd_data = DATA_W'(cnt_q);
      default:  rd_data = '0;
    endcase
  end

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_guarded(wr_addr) && !unlocked) |=> ($stable(match_q) && $stable(en_q))); // R4
  AST_NO_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> !irq); // R7

endmodule

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] K1 = 3'd0, K2 = 3'd1, ST = 3'd2, MT = 3'd3,
                         EN = 3'd4, RS = 3'd5, CT = 3'd6;

  always #2.5 clk = ~clk;

  kwdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gwr(input logic [2:0] a, input logic [15:0] d);
    wr(K1, 16'hBABA);
    wr(K2, 16'hEB10);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic quiesce();
    gwr(EN, 16'h0);
    gwr(RS, 16'h0);
    gwr(ST, 16'h0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(CT, v); check("R1 count", v, 0);
    rd(ST, v); check("R1 status", v, 0);
    rd(EN, v); check("R1 enable", v, 0);
    rd(MT, v); check("R1 match", v, 16'hFFFF);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_unlock();
    logic [15:0] v;
    gwr(MT, 16'h1234);
    rd(MT, v); check("R2 match written", v, 16'h1234);
    wr(MT, 16'h5555);
    rd(MT, v); check("R2 locked write ignored", v, 16'h1234);
  endtask

  task automatic t_single_use();
    logic [15:0] v;
    gwr(MT, 16'h0100);
    wr(MT, 16'h0200);
    rd(MT, v); check("R3 second write ignored", v, 16'h0100);
    wr(EN, 16'h3);
    rd(EN, v); check("R3 enable untouched", v, 0);
  endtask

  task automatic t_bad_keys();
    logic [15:0] v;
    gwr(MT, 16'h00AA);
    wr(K1, 16'hBABB); wr(K2, 16'hEB10); wr(MT, 16'h0011);
    rd(MT, v); check("R4 wrong first key", v, 16'h00AA);
    wr(K1, 16'hBABA); wr(K2, 16'hEB11); wr(MT, 16'h0022);
    rd(MT, v); check("R4 wrong second key", v, 16'h00AA);
    wr(K2, 16'hEB10); wr(MT, 16'h0033);
    rd(MT, v); check("R4 second key alone", v, 16'h00AA);
    wr(K2, 16'hEB10); wr(K1, 16'hBABA); wr(MT, 16'h0044);
    rd(MT, v); check("R4 reversed order / half open", v, 16'h00AA);
    wr(K1, 16'hBABA); wr(K2, 16'hEB10); wr(K1, 16'h0000); wr(MT, 16'h0055);
    rd(MT, v); check("R4 wrong key after open", v, 16'h00AA);
  endtask

  task automatic t_count_match();
    logic [15:0] v;
    quiesce();
    gwr(MT, 16'd12);
    rd(CT, v); check("R5 held while off", v, 0);
    gwr(EN, 16'h1);
    rd(CT, v); check("R11 count read, start", v, 0);
    repeat (5) @(negedge clk);
    rd(CT, v); check("R5 count after 5", v, 5);
    repeat (7) @(negedge clk);
    rd(CT, v); check("R6 count at match", v, 12);
    rd(ST, v); check("R6 no event yet", v, 0);
    check("R7 irq low before match", irq, 0);
    @(negedge clk);
    rd(ST, v); check("R6 event set", v, 1);
    rd(CT, v); check("R6 count wrapped", v, 0);
    check("R7 irq high", irq, 1);
    check("R8 no pulse when bit1 clear", rst_req, 0);
    gwr(EN, 16'h0);
    rd(ST, v); check("R7 event kept", v, 1);
    check("R7 irq low when stopped", irq, 0);
    rd(CT, v);
    repeat (3) @(negedge clk);
    begin
      logic [15:0] w;
      rd(CT, w); check("R5 count holds when off", w, v);
    end
  endtask

  task automatic t_pulse();
    logic [15:0] v;
    quiesce();
    gwr(MT, 16'd30);
    gwr(EN, 16'h3);
    repeat (30) @(negedge clk);
    check("R8 low before match", rst_req, 0);
    @(negedge clk);
    rd(ST, v); check("R8 event at match", v, 1);
    check("R8 pulse starts", rst_req, 1);
    repeat (15) @(negedge clk);
    check("R8 pulse at cycle 16", rst_req, 1);
    @(negedge clk);
    check("R8 pulse ends after 16", rst_req, 0);
    gwr(EN, 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    int guard;
    quiesce();
    gwr(MT, 16'd20);
    gwr(EN, 16'h1);
    repeat (21) @(negedge clk);
    rd(ST, v); check("R9 first event", v, 1);
    gwr(ST, 16'h0001);
    rd(ST, v); check("R9 nonzero write keeps event", v, 1);
    wr(K1, 16'hBABA);
    wr(K2, 16'hEB10);
    guard = 0;
    forever begin
      @(negedge clk);
      rd(CT, v);
      guard++;
      if (v == 16'd20 || guard > 100) break;
    end
    wr_en = 1'b1; wr_addr = ST; wr_data = 16'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(ST, v); check("R9 match wins over clear", v, 1);
    rd(CT, v); check("R6 wrapped on collision", v, 0);
    gwr(ST, 16'h0);
    rd(ST, v); check("R9 clear off-match", v, 0);
    check("R7 irq follows clear", irq, 0);
    gwr(EN, 16'h0);
  endtask

  task automatic t_restart();
    logic [15:0] v, w;
    quiesce();
    gwr(MT, 16'hFFFF);
    gwr(EN, 16'h1);
    repeat (9) @(negedge clk);
    gwr(EN, 16'h0);
    rd(CT, v);
    check("R11 count nonzero", (v != 0), 1);
    wr(RS, 16'h0);
    rd(CT, w); check("R10 locked restart ignored", w, v);
    gwr(RS, 16'h7);
    rd(CT, w); check("R10 restart zeroes", w, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_single_use();
    t_bad_keys();
    t_count_match();
    t_pulse();
    t_clear();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule